// File: doc/BRIEF.md
# Multiprocessor-Capable Start-Stop Serial Transmitter

This block turns bytes written on a parallel valid/ready port into start-stop serial characters on one output line. A one-entry holding register takes the byte. The byte then moves into a shift register, which drives the line. While one character shifts out, the next byte can already sit in the holding register. This lets characters leave back to back with no idle time between them.

The character format is chosen by static inputs: 7 or 8 data bits, 1 or 2 stop bits, and an optional extra bit. The extra bit is either even or odd parity, or a multiprocessor address/data flag supplied with each byte. Every bit lasts 16 ticks of a bit-rate enable. The enable comes from an internal divider, or from rising edges of an external clock that are first synchronised to the system clock. The format is captured when a byte enters the shift register, so changing the format inputs never corrupts a character already in flight.

The control state machine has five states:
- `ST_IDLE`: the line is high.
- `ST_START`: the start bit is being sent.
- `ST_DATA`: the data bits are being sent.
- `ST_EXTRA`: the parity or multiprocessor bit is being sent.
- `ST_STOP`: the stop bits are being sent.

Its transitions are:
- IDLE→START when the holding register is full.
- START→DATA at the end of the start bit.
- DATA→EXTRA or DATA→STOP after the last data bit, depending on whether an extra bit is enabled.
- EXTRA→STOP after the extra bit.
- STOP→START (reload) when the last stop bit ends and a byte is waiting.
- STOP→IDLE when the last stop bit ends and nothing is waiting.

Top module: `mp_async_tx`

## Requirements
- R1: After reset, `txd` is 1, `wr_ready` is 1 and `tx_end` is 1.
- R2: A character is one start bit (0), then the data bits least significant bit first, then the optional extra bit, then the stop bits (1). With the 8-bit format, all eight bits of `wr_data` are sent.
- R3: With `fmt_short`=1, only `wr_data[6:0]` is sent, and `wr_data[7]` has no effect on the line.
- R4: `fmt_two_stop`=1 sends two stop bits; otherwise one is sent.
- R5: With `par_enable`=1 and `mp_enable`=0, a parity bit follows the data bits. `par_odd`=0 makes the count of ones over the sent data bits plus parity even. `par_odd`=1 makes that count odd.
- R6: With `mp_enable`=1, the extra bit equals the `wr_mp_flag` value captured with the byte. No parity bit is sent, whatever `par_enable` is.
- R7: `wr_ready` is 1 exactly when the holding register is empty. A byte written while another is shifting is sent next. Its start bit begins in the clock cycle right after the previous character's last stop bit ends, with no idle time.
- R8: Each bit lasts 16 ticks. With `ext_clk_sel`=0, a tick occurs once every `baud_div`+1 clock cycles.
- R9: With `ext_clk_sel`=1, a tick occurs once per rising edge of `ext_clk_in`, after a two-flop synchroniser. A bit then lasts 16 periods of `ext_clk_in`.
- R10: `tx_end` is 1 exactly when the machine is in `ST_IDLE` and the holding register is empty. While `tx_end` is 1, `txd` is 1.
- R11: A write presented while `wr_ready` is 0 is ignored. The byte already held is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_sel | input | 1 | 1: tick from `ext_clk_in`; 0: tick from internal divider |
| baud_div | input | 16 | Internal divider: tick every `baud_div`+1 cycles |
| ext_clk_in | input | 1 | External bit-rate clock, asynchronous |
| fmt_short | input | 1 | 1: 7 data bits; 0: 8 data bits |
| fmt_two_stop | input | 1 | 1: two stop bits |
| par_enable | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1: odd parity; 0: even parity |
| mp_enable | input | 1 | Append the multiprocessor flag instead of parity |
| wr_mp_flag | input | 1 | Multiprocessor flag for the byte being written |
| wr_data | input | 8 | Byte to send |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Holding register empty; write accepted when both are high |
| txd | output | 1 | Serial output, idles high |
| tx_end | output | 1 | Nothing shifting and nothing waiting |

## Verification
The assertions assume the following about the inputs:
- `baud_div` does not change while an internal-tick spacing is being checked.
- `ext_clk_in` holds each level for at least two system clocks, so the synchroniser produces single-cycle tick pulses.

The stimulus holds every format input and `baud_div` steady from before a byte is written until `tx_end` returns high. The one exception is the back-to-back test, which uses a single format throughout. The external clock toggles only every four system cycles. Writes are driven on the falling clock edge and held for exactly one rising edge. Line bits are sampled near the middle of each bit, counted from the detected start edge.

// File: rtl/mptx_pkg.sv
package mptx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_EXTRA,
        ST_STOP
    } tx_state_t;

    typedef struct packed {
        logic short_len;
        logic two_stop;
        logic extra_en;
        logic extra_val;
    } frame_fmt_t;

endpackage

// File: rtl/mptx_tick_gen.sv
module mptx_tick_gen #(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sel,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             ext_clk_in,
    output logic             tick
);
    logic [DIV_W-1:0]     div_cnt_q;
    logic [SYNC_STAGES:0] sync_q;
    logic                 int_tick;
    logic                 ext_tick;

    assign int_tick = (div_cnt_q >= baud_div);
    assign ext_tick = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    assign tick     = ext_sel ? ext_tick : int_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt_q <= '0;
            sync_q    <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk_in};
            if (ext_sel || int_tick) begin
                div_cnt_q <= '0;
            end else begin
                div_cnt_q <= div_cnt_q + 1'b1;
            end
        end
    end

    AST_INT_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_sel && tick && baud_div != '0) ##1 ($stable(baud_div) && !ext_sel) |-> !tick); // R8

    AST_EXT_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && tick) |=> (!ext_sel || !tick)); // R9

endmodule

// File: rtl/mptx_tx_core.sv
module mptx_tx_core
    import mptx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cfg_short,
    input  logic              cfg_two_stop,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_mp_en,
    input  logic              wr_mp,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic              txd,
    output logic              tx_end
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_TICK  = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(DATA_W - 2);

    tx_state_t         state_q, state_d;
    logic [DATA_W-1:0] hold_q;
    logic              hold_mp_q;
    logic              hold_full_q;
    logic [DATA_W-1:0] shreg_q;
    frame_fmt_t        fmt_q, fmt_new;
    logic [CNT_W-1:0]  tick_cnt_q;
    logic [IDX_W-1:0]  bit_idx_q;
    logic              stop_idx_q;
    logic              bit_end, last_data, last_stop, load, accept, data_par;

    assign bit_end   = tick && (tick_cnt_q == LAST_TICK);
    assign last_data = (bit_idx_q == (fmt_q.short_len ? LAST_SHORT : LAST_LONG));
    assign last_stop = (stop_idx_q == fmt_q.two_stop);
    assign load      = hold_full_q &&
                       ((state_q == ST_IDLE) ||
                        ((state_q == ST_STOP) && bit_end && last_stop));
    assign accept    = wr_valid && !hold_full_q;
    assign data_par  = cfg_short ? ^hold_q[DATA_W-2:0] : ^hold_q;

    always_comb begin
        fmt_new.short_len = cfg_short;
        fmt_new.two_stop  = cfg_two_stop;
        fmt_new.extra_en  = cfg_mp_en | cfg_par_en;
        fmt_new.extra_val = cfg_mp_en ? hold_mp_q : (data_par ^ cfg_par_odd);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load) state_d = ST_START;
            ST_START: if (bit_end) state_d = ST_DATA;
            ST_DATA:  if (bit_end && last_data)
                          state_d = fmt_q.extra_en ? ST_EXTRA : ST_STOP;
            ST_EXTRA: if (bit_end) state_d = ST_STOP;
            ST_STOP:  if (bit_end && last_stop)
                          state_d = load ? ST_START : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:  txd = 1'b1;
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg_q[0];
            ST_EXTRA: txd = fmt_q.extra_val;
            ST_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
        wr_ready = !hold_full_q;
        tx_end   = (state_q == ST_IDLE) && !hold_full_q;
    end

    // Holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_mp_q   <= 1'b0;
            hold_full_q <= 1'b0;
        end else if (accept) begin
            hold_q      <= wr_data;
            hold_mp_q   <= wr_mp;
            hold_full_q <= 1'b1;
        end else if (load) begin
            hold_full_q <= 1'b0;
        end
    end

    // Shift register and bit counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            fmt_q      <= '0;
            tick_cnt_q <= '0;
            bit_idx_q  <= '0;
            stop_idx_q <= 1'b0;
        end else if (load) begin
            shreg_q    <= hold_q;
            fmt_q      <= fmt_new;
            tick_cnt_q <= '0;
            bit_idx_q  <= '0;
            stop_idx_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            tick_cnt_q <= '0;
        end else begin
            if (tick) begin
                tick_cnt_q <= (tick_cnt_q == LAST_TICK) ? '0 : tick_cnt_q + 1'b1;
            end
            if (bit_end && state_q == ST_DATA) begin
                shreg_q   <= shreg_q >> 1;
                bit_idx_q <= bit_idx_q + 1'b1;
            end
            if (bit_end && state_q == ST_STOP && !last_stop) begin
                stop_idx_q <= 1'b1;
            end
        end
    end

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_end |-> txd); // R10

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !tx_end); // R10

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full_q && wr_valid) |=> $stable(hold_q)); // R11

    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && bit_end && last_stop && hold_full_q)
        |=> (state_q == ST_START && !txd)); // R7

    AST_BIT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !bit_end) |=> $stable(state_q)); // R8

endmodule

// File: rtl/mp_async_tx.sv
module mp_async_tx #(
    parameter int DIV_W       = 16,
    parameter int OVS         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk_sel,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              ext_clk_in,
    input  logic              fmt_short,
    input  logic              fmt_two_stop,
    input  logic              par_enable,
    input  logic              par_odd,
    input  logic              mp_enable,
    input  logic              wr_mp_flag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic              txd,
    output logic              tx_end
);
    logic bit_tick;

    mptx_tick_gen #(
        .DIV_W      (DIV_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) tick_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_sel   (ext_clk_sel),
        .baud_div  (baud_div),
        .ext_clk_in(ext_clk_in),
        .tick      (bit_tick)
    );

    mptx_tx_core #(
        .OVS   (OVS),
        .DATA_W(DATA_W)
    ) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (bit_tick),
        .cfg_short   (fmt_short),
        .cfg_two_stop(fmt_two_stop),
        .cfg_par_en  (par_enable),
        .cfg_par_odd (par_odd),
        .cfg_mp_en   (mp_enable),
        .wr_mp       (wr_mp_flag),
        .wr_data     (wr_data),
        .wr_valid    (wr_valid),
        .wr_ready    (wr_ready),
        .txd         (txd),
        .tx_end      (tx_end)
    );

endmodule

// File: tb/mp_async_tx_tb_top.sv
`timescale 1ns/1ps
module mp_async_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk_sel = 1'b0;
    logic [15:0] baud_div = '0;
    logic        ext_clk_in = 1'b0;
    logic        ext_run = 1'b0;
    logic        fmt_short = 1'b0, fmt_two_stop = 1'b0, par_enable = 1'b0;
    logic        par_odd = 1'b0, mp_enable = 1'b0, wr_mp_flag = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready, txd, tx_end;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;
    always #20 ext_clk_in = ext_run ? ~ext_clk_in : 1'b0;

    mp_async_tx dut_i (
        .clk(clk), .rst_n(rst_n), .ext_clk_sel(ext_clk_sel), .baud_div(baud_div),
        .ext_clk_in(ext_clk_in), .fmt_short(fmt_short), .fmt_two_stop(fmt_two_stop),
        .par_enable(par_enable), .par_odd(par_odd), .mp_enable(mp_enable),
        .wr_mp_flag(wr_mp_flag), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .txd(txd), .tx_end(tx_end)
    );

    // Vector fields: [13] mp flag, [12] mp_en, [11] odd, [10] par_en, [9] two_stop, [8] short, [7:0] data
    localparam int NV = 12;
    localparam logic [13:0] VEC [NV] = '{
        {6'b000000, 8'hA5}, {6'b000000, 8'h01}, {6'b000001, 8'hFF},
        {6'b000010, 8'h3C}, {6'b000100, 8'h07}, {6'b001100, 8'h07},
        {6'b001111, 8'h80}, {6'b110000, 8'h55}, {6'b010100, 8'hC3},
        {6'b111111, 8'h7E}, {6'b000111, 8'h00}, {6'b000000, 8'hFF}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply_fmt(input logic [13:0] v);
        fmt_short    = v[8];
        fmt_two_stop = v[9];
        par_enable   = v[10];
        par_odd      = v[11];
        mp_enable    = v[12];
    endtask

    task automatic build(input logic [13:0] v, output logic [12:0] f, output int len);
        int n;
        logic p;
        f = '0;
        n = v[8] ? 7 : 8;
        p = v[11];
        f[0] = 1'b0;
        for (int i = 0; i < n; i++) begin
            f[1+i] = v[i];
            p ^= v[i];
        end
        len = 1 + n;
        if (v[12] || v[10]) begin
            f[len] = v[12] ? v[13] : p;
            len++;
        end
        f[len] = 1'b1;
        len++;
        if (v[9]) begin
            f[len] = 1'b1;
            len++;
        end
    endtask

    task automatic push(input logic [7:0] d, input logic mp);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_data    = d;
        wr_mp_flag = mp;
        wr_valid   = 1'b1;
        @(negedge clk);
        wr_valid   = 1'b0;
    endtask

    task automatic capture(input int len, input int per, output logic [12:0] got, output int gap);
        got = '0;
        while (txd !== 1'b0) @(negedge clk);
        repeat (per / 2) @(negedge clk);
        got[0] = txd;
        for (int k = 1; k < len; k++) begin
            repeat (per) @(negedge clk);
            got[k] = txd;
        end
        gap = 0;
        while (txd === 1'b1 && gap < 2 * per) begin
            @(negedge clk);
            gap++;
        end
    endtask

    task automatic run_one(input logic [13:0] v, input int per, input string tag);
        logic [12:0] exp_f, got_f;
        int len, gap;
        apply_fmt(v);
        build(v, exp_f, len);
        fork
            push(v[7:0], v[13]);
            capture(len, per, got_f, gap);
        join
        chk(tag, 16'(got_f), 16'(exp_f));
        while (!tx_end) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [12:0] e1, e2, g1, g2;
        int l1, l2, gp1, gp2;
        string tag;

        repeat (3) @(negedge clk);
        chk("R1 txd", 16'(txd), 16'd1);
        chk("R1 wr_ready", 16'(wr_ready), 16'd1);
        chk("R1 tx_end", 16'(tx_end), 16'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Format table walk, internal tick every cycle: 16-cycle bits
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][12])      tag = "R6 mp bit";
            else if (VEC[i][10]) tag = "R5 parity";
            else if (VEC[i][9])  tag = "R4 two stop";
            else if (VEC[i][8])  tag = "R3 short";
            else                 tag = "R2 frame";
            run_one(VEC[i], 16, tag);
            chk("R10 tx_end after frame", 16'(tx_end), 16'd1);
        end

        // R7 / R11: back-to-back frames, and a write ignored while full
        apply_fmt(14'h0000);
        build({6'b000000, 8'h5A}, e1, l1);
        build({6'b000000, 8'hC1}, e2, l2);
        fork
            begin
                push(8'h5A, 1'b0);
                push(8'hC1, 1'b0);
                @(negedge clk);
                chk("R7 ready low while held", 16'(wr_ready), 16'd0);
                chk("R10 tx_end low while busy", 16'(tx_end), 16'd0);
                wr_data  = 8'hEE;
                wr_valid = 1'b1;
                repeat (20) @(negedge clk);
                wr_valid = 1'b0;
            end
            begin
                capture(l1, 16, g1, gp1);
                capture(l2, 16, g2, gp2);
            end
        join
        chk("R7 first frame", 16'(g1), 16'(e1));
        chk("R7 no gap", 16'(gp1), 16'd8);
        chk("R11 held byte kept", 16'(g2), 16'(e2));
        while (!tx_end) @(negedge clk);

        // R8: divider 2 -> tick every 3 cycles -> 48-cycle bits
        baud_div = 16'd2;
        run_one({6'b000100, 8'h96}, 48, "R8 divided tick");
        baud_div = 16'd0;

        // R9: external clock period 8 cycles -> 128-cycle bits
        ext_clk_sel = 1'b1;
        ext_run     = 1'b1;
        run_one({6'b110010, 8'h3B}, 128, "R9 external tick");
        ext_run     = 1'b0;
        ext_clk_sel = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 idle line", 16'(txd), 16'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule